// File: doc/BRIEF.md
# Vector Length Block Executor

This block carries out the optional 16-bit length block of a vector instruction group. A two-bit mode and its fields arrive with a one-cycle strobe. The block works out the new vector length (VL) and, in one mode, a new maximum vector length (MVL). It also drives an integer register write port so that the destination register gets the resulting length, just as a length-setting instruction would.

There are three useful modes. The first sets VL from an immediate that is clipped to the current MVL. The second sets VL from a register operand, again clipped to MVL, with both the source and the destination taken from the compact register window x8..x15. The third sets MVL and VL together to the immediate. The fourth mode value is reserved: when all of its fields are zero it does nothing, and otherwise it is flagged as illegal with no state change.

The source register value is read through a combinational read address, so the register file answers in the same cycle as the strobe. All results are registered and appear one cycle after the strobe, together with a done pulse.

Top module: `vlblk_exec`

## Requirements
- R1: After a synchronous reset, done, illegal, vl_we, mvl_we and wr_en are 0, and vl_out and mvl_out are 0.
- R2: Mode value 0 sets vl_out to min(imm, cur_mvl) and sets mvl_out to cur_mvl, with vl_we=1 and mvl_we=0.
- R3: Mode value 2 sets both vl_out and mvl_out to imm, with vl_we=1 and mvl_we=1, whatever cur_mvl is.
- R4: Mode value 1 drives rs1_addr = 8 + rs1_c (combinationally, in the strobe cycle), sets vl_out to min(rs1_val, cur_mvl) using the full XLEN-wide rs1_val, sets mvl_out to cur_mvl, and always writes the new VL to register 8 + rd_c.
- R5: In mode values 0 and 2 the new VL, zero-extended to XLEN, is written to register rd_f when rd_f is not 0. When rd_f is 0, wr_en stays 0.
- R6: Mode value 3 with any of imm, rd_f, rs1_c or rd_c nonzero pulses illegal with done. It raises none of wr_en, vl_we or mvl_we, and leaves vl_out and mvl_out unchanged.
- R7: Mode value 3 with all those fields zero pulses done only. It leaves illegal, wr_en, vl_we and mvl_we at 0 and vl_out and mvl_out unchanged.
- R8: Every output appears exactly one cycle after a go strobe, and done is high for that one cycle only. Without go, no pulse is raised and vl_out and mvl_out hold their values. Back-to-back strobes each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | One-cycle request strobe |
| mode | input | 2 | Mode: 0 clip, 1 register, 2 set both, 3 reserved |
| imm | input | VL_W | Immediate length |
| rd_f | input | 5 | Full destination index (modes 0 and 2) |
| rs1_c | input | 3 | Compact source index (mode 1) |
| rd_c | input | 3 | Compact destination index (mode 1) |
| rs1_addr | output | 5 | Register file read address, 8 + rs1_c |
| rs1_val | input | XLEN | Value read at rs1_addr |
| cur_mvl | input | VL_W | Current MVL |
| done | output | 1 | Result valid pulse |
| illegal | output | 1 | Reserved mode with nonzero fields |
| vl_we | output | 1 | VL update pulse |
| mvl_we | output | 1 | MVL update pulse |
| vl_out | output | VL_W | New VL (held) |
| mvl_out | output | VL_W | New MVL (held) |
| wr_en | output | 1 | Integer register write enable |
| wr_addr | output | 5 | Integer register write index |
| wr_data | output | XLEN | Integer register write data |

## Verification
The bench aims at the clip boundaries: an immediate or rs1 value equal to, one above and far above MVL, and an rs1 value whose only set bits lie above the VL width. A design that compares only the low bits would return a small wrapped length instead of MVL. It drives rd_f of zero, where a careless design would write x0. It drives mode 2 with a cur_mvl smaller than the immediate, where a design that clips there would shrink VL. It tests the reserved mode with each field nonzero by itself, where a design that checks only some fields would miss the illegal flag or would corrupt VL. Back-to-back strobes and idle gaps catch extra-long or missing done pulses.

// File: rtl/vlblk_pkg.sv
package vlblk_pkg;

  typedef enum logic [1:0] {
    VM_CLIP = 2'b00,
    VM_REG  = 2'b01,
    VM_BOTH = 2'b10,
    VM_RSV  = 2'b11
  } vmode_e;

  localparam int REG_W = 5;
  localparam int CMP_W = 3;
  // compact window starts at x8: the top two index bits are 01
  localparam logic [REG_W-CMP_W-1:0] CMP_HI = 2'b01;

endpackage

// File: rtl/vlblk_decode.sv
module vlblk_decode
  import vlblk_pkg::*;
#(
  parameter int VL_W = 8
) (
  input  logic [1:0]       mode,
  input  logic [VL_W-1:0]  imm,
  input  logic [REG_W-1:0] rd_f,
  input  logic [CMP_W-1:0] rs1_c,
  input  logic [CMP_W-1:0] rd_c,
  output vmode_e           kind,
  output logic             rsv_bad,
  output logic [REG_W-1:0] src_addr,
  output logic [REG_W-1:0] dst_addr,
  output logic             dst_ok
);

  logic any_field;

  assign kind      = vmode_e'(mode);
  assign any_field = (|imm) | (|rd_f) | (|rs1_c) | (|rd_c);
  assign rsv_bad   = (kind == VM_RSV) && any_field;
  assign src_addr  = {CMP_HI, rs1_c};

  always_comb begin
    dst_addr = '0;
    dst_ok   = 1'b0;
    unique case (kind)
      VM_REG: begin
        dst_addr = {CMP_HI, rd_c};
        dst_ok   = 1'b1;
      end
      VM_CLIP, VM_BOTH: begin
        dst_addr = rd_f;
        dst_ok   = (rd_f != '0);
      end
      default: begin
        dst_addr = '0;
        dst_ok   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/vlblk_clamp.sv
module vlblk_clamp #(
  parameter int SRC_W = 32,
  parameter int LIM_W = 8
) (
  input  logic [SRC_W-1:0] src,
  input  logic [LIM_W-1:0] lim,
  output logic [LIM_W-1:0] res
);

  generate
    if (SRC_W > LIM_W) begin : g_wide
      logic hi_set;
      assign hi_set = |src[SRC_W-1:LIM_W];
      assign res    = (hi_set || (src[LIM_W-1:0] > lim)) ? lim : src[LIM_W-1:0];
    end else begin : g_narrow
      logic [LIM_W-1:0] ext;
      assign ext = LIM_W'(src);
      assign res = (ext > lim) ? lim : ext;
    end
  endgenerate

endmodule

// File: rtl/vlblk_exec.sv
module vlblk_exec
  import vlblk_pkg::*;
#(
  parameter int VL_W = 8,
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [1:0]       mode,
  input  logic [VL_W-1:0]  imm,
  input  logic [4:0]       rd_f,
  input  logic [2:0]       rs1_c,
  input  logic [2:0]       rd_c,
  output logic [4:0]       rs1_addr,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [VL_W-1:0]  cur_mvl,
  output logic             done,
  output logic             illegal,
  output logic             vl_we,
  output logic             mvl_we,
  output logic [VL_W-1:0]  vl_out,
  output logic [VL_W-1:0]  mvl_out,
  output logic             wr_en,
  output logic [4:0]       wr_addr,
  output logic [XLEN-1:0]  wr_data
);

  localparam int PAD_W = XLEN - VL_W;

  vmode_e           kind;
  logic             rsv_bad;
  logic [REG_W-1:0] dst_addr;
  logic             dst_ok;
  logic [VL_W-1:0]  imm_clip;
  logic [VL_W-1:0]  reg_clip;

  logic [VL_W-1:0]  nx_vl;
  logic [VL_W-1:0]  nx_mvl;
  logic             nx_upd;
  logic             nx_mvl_we;

  vlblk_decode #(.VL_W(VL_W)) u_dec (
    .mode     (mode),
    .imm      (imm),
    .rd_f     (rd_f),
    .rs1_c    (rs1_c),
    .rd_c     (rd_c),
    .kind     (kind),
    .rsv_bad  (rsv_bad),
    .src_addr (rs1_addr),
    .dst_addr (dst_addr),
    .dst_ok   (dst_ok)
  );

  vlblk_clamp #(.SRC_W(VL_W), .LIM_W(VL_W)) u_clip_imm (
    .src (imm),
    .lim (cur_mvl),
    .res (imm_clip)
  );

  vlblk_clamp #(.SRC_W(XLEN), .LIM_W(VL_W)) u_clip_reg (
    .src (rs1_val),
    .lim (cur_mvl),
    .res (reg_clip)
  );

  always_comb begin
    nx_vl     = vl_out;
    nx_mvl    = mvl_out;
    nx_upd    = 1'b0;
    nx_mvl_we = 1'b0;
    unique case (kind)
      VM_CLIP: begin
        nx_vl  = imm_clip;
        nx_mvl = cur_mvl;
        nx_upd = 1'b1;
      end
      VM_REG: begin
        nx_vl  = reg_clip;
        nx_mvl = cur_mvl;
        nx_upd = 1'b1;
      end
      VM_BOTH: begin
        nx_vl     = imm;
        nx_mvl    = imm;
        nx_upd    = 1'b1;
        nx_mvl_we = 1'b1;
      end
      default: begin
        nx_upd = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      illegal <= 1'b0;
      vl_we   <= 1'b0;
      mvl_we  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      vl_out  <= '0;
      mvl_out <= '0;
    end else begin
      done    <= go;
      illegal <= go && rsv_bad;
      vl_we   <= go && nx_upd;
      mvl_we  <= go && nx_mvl_we;
      wr_en   <= go && nx_upd && dst_ok;
      if (go && nx_upd) begin
        vl_out  <= nx_vl;
        mvl_out <= nx_mvl;
        wr_addr <= dst_addr;
        wr_data <= {{PAD_W{1'b0}}, nx_vl};
      end
    end
  end

  // R2: a clipped length never exceeds the MVL it was clipped against
  p_vl_le_mvl_r2: assert property (@(posedge clk) disable iff (rst)
    vl_we |-> (vl_out <= mvl_out));

  // R3: setting both leaves VL equal to MVL
  p_both_equal_r3: assert property (@(posedge clk) disable iff (rst)
    mvl_we |-> (vl_we && (vl_out == mvl_out)));

  // R4: register mode writes only inside the compact window
  p_cmp_window_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ($past(mode) == 2'b01)) |-> (wr_addr[4:3] == 2'b01));

  // R5: register x0 is never written
  p_no_x0_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr != 5'd0));

  // R6: an illegal request changes nothing
  p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (done && !wr_en && !vl_we && !mvl_we));

  p_illegal_hold_r6: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($stable(vl_out) && $stable(mvl_out)));

  // R8: one result pulse per strobe, one cycle later
  p_done_follows_r8: assert property (@(posedge clk) disable iff (rst)
    go |=> done);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    !go |=> (!done && $stable(vl_out) && $stable(mvl_out)));

endmodule

// File: tb/vlblk_exec_tb_top.sv
`timescale 1ns/1ps
module vlblk_exec_tb_top;

  localparam int VL_W = 8;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            go = 1'b0;
  logic [1:0]      mode = '0;
  logic [VL_W-1:0] imm = '0;
  logic [4:0]      rd_f = '0;
  logic [2:0]      rs1_c = '0;
  logic [2:0]      rd_c = '0;
  logic [XLEN-1:0] rs1_val = '0;
  logic [VL_W-1:0] cur_mvl = '0;

  logic [4:0]      rs1_addr;
  logic            done, illegal, vl_we, mvl_we, wr_en;
  logic [VL_W-1:0] vl_out, mvl_out;
  logic [4:0]      wr_addr;
  logic [XLEN-1:0] wr_data;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  vlblk_exec #(.VL_W(VL_W), .XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .go(go), .mode(mode), .imm(imm), .rd_f(rd_f),
    .rs1_c(rs1_c), .rd_c(rd_c), .rs1_addr(rs1_addr), .rs1_val(rs1_val),
    .cur_mvl(cur_mvl), .done(done), .illegal(illegal), .vl_we(vl_we),
    .mvl_we(mvl_we), .vl_out(vl_out), .mvl_out(mvl_out), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference, stepped on every clock
  int    e_vl = 0, e_mvl = 0;
  bit    e_done, e_ill, e_vlwe, e_mvlwe, e_wen;
  int    e_waddr;
  longint e_wdata;
  string tag;

  always begin
    @(posedge clk);
    e_done = 0; e_ill = 0; e_vlwe = 0; e_mvlwe = 0; e_wen = 0;
    e_waddr = 0; e_wdata = 0;
    if (rst) begin
      e_vl = 0; e_mvl = 0; tag = "R1";
    end else if (!go) begin
      tag = "R8";
    end else begin
      e_done = 1;
      case (mode)
        2'd0: begin
          tag = "R2";
          e_vl = (int'(imm) < int'(cur_mvl)) ? int'(imm) : int'(cur_mvl);
          e_mvl = int'(cur_mvl); e_vlwe = 1;
          if (rd_f != 0) begin e_wen = 1; e_waddr = int'(rd_f); e_wdata = e_vl; end
        end
        2'd1: begin
          tag = "R4";
          e_vl = (longint'(rs1_val) < longint'(cur_mvl)) ? int'(rs1_val) : int'(cur_mvl);
          e_mvl = int'(cur_mvl); e_vlwe = 1;
          e_wen = 1; e_waddr = 8 + int'(rd_c); e_wdata = e_vl;
        end
        2'd2: begin
          tag = "R3";
          e_vl = int'(imm); e_mvl = int'(imm); e_vlwe = 1; e_mvlwe = 1;
          if (rd_f != 0) begin e_wen = 1; e_waddr = int'(rd_f); e_wdata = e_vl; end
        end
        default: begin
          if (imm != 0 || rd_f != 0 || rs1_c != 0 || rd_c != 0) begin
            tag = "R6"; e_ill = 1;
          end else tag = "R7";
        end
      endcase
    end
    #1;
    if (!ended) begin
      chk(done == e_done, tag, "done", done, e_done);
      chk(illegal == e_ill, tag, "illegal", illegal, e_ill);
      chk(vl_we == e_vlwe, tag, "vl_we", vl_we, e_vlwe);
      chk(mvl_we == e_mvlwe, tag, "mvl_we", mvl_we, e_mvlwe);
      chk(wr_en == e_wen, (e_done && !e_wen && mode != 2'd3) ? "R5" : tag, "wr_en", wr_en, e_wen);
      chk(int'(vl_out) == e_vl, tag, "vl_out", vl_out, e_vl);
      chk(int'(mvl_out) == e_mvl, tag, "mvl_out", mvl_out, e_mvl);
      if (e_wen) begin
        chk(int'(wr_addr) == e_waddr, "R5", "wr_addr", wr_addr, e_waddr);
        chk(longint'(wr_data) == e_wdata, "R5", "wr_data", wr_data, e_wdata);
      end
    end
  end

  task automatic issue(input logic [1:0] m, input logic [VL_W-1:0] i,
                       input logic [4:0] rd, input logic [2:0] rs, input logic [2:0] rdc,
                       input logic [XLEN-1:0] rv, input logic [VL_W-1:0] mv);
    @(negedge clk);
    go = 1; mode = m; imm = i; rd_f = rd; rs1_c = rs; rd_c = rdc;
    rs1_val = rv; cur_mvl = mv;
    #1;
    if (m == 2'd1)
      chk(int'(rs1_addr) == 8 + int'(rs), "R4", "rs1_addr", rs1_addr, 8 + int'(rs));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      go = 0;
      imm = 8'hA5; cur_mvl = 8'h11;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    // R2 clip mode
    issue(2'd0, 8'd5, 5'd3, 3'd0, 3'd0, '0, 8'd20);
    issue(2'd0, 8'd20, 5'd4, 3'd0, 3'd0, '0, 8'd20);
    issue(2'd0, 8'd21, 5'd31, 3'd0, 3'd0, '0, 8'd20);
    issue(2'd0, 8'd255, 5'd0, 3'd0, 3'd0, '0, 8'd7);   // R5 rd=0
    idle(1);
    // R3 set both, cur_mvl smaller than imm
    issue(2'd2, 8'd200, 5'd9, 3'd0, 3'd0, '0, 8'd4);
    issue(2'd2, 8'd0, 5'd0, 3'd0, 3'd0, '0, 8'd4);
    issue(2'd2, 8'd255, 5'd1, 3'd7, 3'd7, '0, 8'd0);
    // R4 register mode
    issue(2'd1, 8'd0, 5'd0, 3'd2, 3'd5, 32'd9, 8'd16);
    issue(2'd1, 8'd0, 5'd0, 3'd7, 3'd0, 32'd16, 8'd16);
    issue(2'd1, 8'd0, 5'd0, 3'd0, 3'd7, 32'd17, 8'd16);
    issue(2'd1, 8'd0, 5'd0, 3'd1, 3'd1, 32'h0000_0100, 8'd200);
    issue(2'd1, 8'd0, 5'd0, 3'd3, 3'd3, 32'h8000_0003, 8'd50);
    issue(2'd1, 8'd0, 5'd0, 3'd4, 3'd2, 32'd0, 8'd50);
    idle(2);
    // R7 reserved no-op, R6 each field alone
    issue(2'd3, 8'd0, 5'd0, 3'd0, 3'd0, 32'hFFFF_FFFF, 8'd99);
    issue(2'd3, 8'd1, 5'd0, 3'd0, 3'd0, '0, 8'd1);
    issue(2'd3, 8'd0, 5'd16, 3'd0, 3'd0, '0, 8'd1);
    issue(2'd3, 8'd0, 5'd0, 3'd4, 3'd0, '0, 8'd1);
    issue(2'd3, 8'd0, 5'd0, 3'd0, 3'd1, '0, 8'd1);
    idle(3);
    // mixed random traffic with gaps (R2..R8)
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      logic [XLEN-1:0] rv;
      m = 2'($urandom_range(0, 3));
      rv = ($urandom_range(0, 1) == 1) ? 32'($urandom_range(0, 300)) : 32'($urandom);
      if (m == 2'd3 && $urandom_range(0, 1) == 1)
        issue(m, '0, '0, '0, '0, rv, 8'($urandom));
      else
        issue(m, 8'($urandom), 5'($urandom_range(0, 3) == 0 ? 0 : $urandom),
              3'($urandom), 3'($urandom), rv, 8'($urandom));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(2);
    // R1 reset mid-stream
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    idle(2);
    @(posedge clk); #2;
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule